// File: doc/BRIEF.md
# Complementary PWM Dead-Time Inserter

This block turns a single PWM waveform bit into two drive signals for a half bridge: a true output for the high-side switch and a complementary output for the low-side switch. Whenever the waveform changes level, the output that was on is switched off at once. The output that is due to switch on is held low for a programmed dead time, so the two switches never conduct together.

The dead time comes from an 8-bit configuration word. The upper nibble sets the delay before the true output rises, and the lower nibble sets the delay before the complementary output rises. A 4-bit down counter counts the delay on ticks from a private prescaler. The prescaler divides the clock by 1, 2, 4 or 8, and it restarts on every waveform edge, so each interval has the same length every time. Even with a zero setting, the output that switches on lags the one that switches off by one clock.

All pins are plain level signals. The waveform is a level, not a stream of transfers, so there is no valid/ready handshake and no back-pressure. The output pair follows the most recent waveform level, and a level that lasts only a few clocks simply restarts the dead time.

Top module: `pwm_deadtime_gen`

## Requirements
- R1: `drv_hi` and `drv_lo` are never both high.
- R2: While reset is asserted, and on the first clocks after it with `enable` low, both outputs are low. Reset leaves the counter and the prescaler at zero.
- R3: If `wave_in` is sampled low at a rising clock edge, `drv_hi` is low after that edge. If `wave_in` is sampled high, `drv_lo` is low after that edge.
- R4: The first clock edge that samples `wave_in` high after it was low is the edge clock. After the edge clock, `drv_hi` stays low for exactly N*D+1 clocks and then rises. Here N is `dt_cfg[7:4]` and D is the prescaler division.
- R5: The first clock edge that samples `wave_in` low after it was high is the edge clock. After the edge clock, `drv_lo` stays low for exactly N*D+1 clocks and then rises. Here N is `dt_cfg[3:0]`.
- R6: The division D is set by `ps_sel`: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R7: A waveform edge that arrives before a pending dead time has expired reloads the counter with the nibble for the new edge. The output that was pending never rises.
- R8: If `enable` is sampled low, both outputs are low after that edge. Every disabled clock restarts the dead time for the current waveform level. If `enable` rises before edge e, the matching output rises after edge e+N*D-1+1 (that is, N*D clocks after the first enabled edge).
- R9: With a zero nibble, the output that switches on rises exactly one clock after the one that switches off. The rising output is never high in the clock right after the other one was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Complementary dead-time mode active; outputs are blanked when low |
| dt_cfg | input | 8 | Dead times: [7:4] before the true output rises, [3:0] before the complementary output rises |
| ps_sel | input | 2 | Prescaler select: the tick divides the clock by 2^ps_sel |
| wave_in | input | 1 | PWM waveform bit |
| drv_hi | output | 1 | True (high-side) drive |
| drv_lo | output | 1 | Complementary (low-side) drive |

## Verification
The properties are checked on every clock:
- the two outputs never overlap;
- each output is off right after the waveform level calls for it to be off;
- both outputs blank right after a disabled clock;
- a rising output always has at least one clock of gap behind the other output.

The exact lengths of the dead times cannot be shown by those properties. Only the bench scenarios can show them for every nibble at all four prescaler settings, the choice of high or low nibble by edge direction, the discard of a pending turn-on when the waveform retriggers, and the restart after re-enable.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;
  typedef enum logic {
    SIDE_LO = 1'b0,
    SIDE_HI = 1'b1
  } side_e;
endpackage

// File: rtl/dt_edge_detect.sv
module dt_edge_detect
  import pwm_dt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enable,
  input  logic  wave_in,
  output side_e level,
  output logic  restart
);
  // Registered copy of the waveform; a mismatch is an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= SIDE_LO;
    else        level <= side_e'(wave_in);
  end

  // A disabled clock behaves like an edge: blank and reload.
  assign restart = !enable || (wave_in != logic'(level));
endmodule

// File: rtl/dt_prescaler.sv
module dt_prescaler #(
  parameter int unsigned PS_W = 2,
  parameter int unsigned PC_W = (1 << PS_W) - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            run,
  input  logic [PS_W-1:0] ps_sel,
  output logic            tick
);
  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] term;

  // Terminal value 2^ps_sel - 1: the low ps_sel bits set.
  always_comb begin
    for (int i = 0; i < PC_W; i++) term[i] = (i < int'(ps_sel));
  end

  assign tick = run && (pc == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc <= '0;
    else if (restart) pc <= '0;
    else if (run) begin
      if (tick) pc <= '0;
      else      pc <= pc + 1'b1;
    end
  end
endmodule

// File: rtl/dt_down_counter.sv
module dt_down_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             busy,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  assign zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b1;
    end else if (load) begin
      cnt  <= load_val;
      busy <= 1'b1;
    end else if (busy) begin
      if (zero)      busy <= 1'b0;
      else if (tick) cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/pwm_deadtime_gen.sv
module pwm_deadtime_gen
  import pwm_dt_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned PS_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [2*CNT_W-1:0] dt_cfg,
  input  logic [PS_W-1:0]    ps_sel,
  input  logic               wave_in,
  output logic               drv_hi,
  output logic               drv_lo
);
  localparam int unsigned CFG_W = 2 * CNT_W;
  localparam int unsigned PC_W  = (1 << PS_W) - 1;

  side_e            level;
  logic             restart;
  logic             busy;
  logic             zero;
  logic             tick;
  logic             fire;
  logic [CNT_W-1:0] load_val;

  dt_edge_detect u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .wave_in (wave_in),
    .level   (level),
    .restart (restart)
  );

  // A rising waveform arms the true side, a falling one the complement.
  assign load_val = wave_in ? dt_cfg[CFG_W-1:CNT_W] : dt_cfg[CNT_W-1:0];

  dt_prescaler #(.PS_W(PS_W), .PC_W(PC_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .run     (busy && !zero && !restart),
    .ps_sel  (ps_sel),
    .tick    (tick)
  );

  dt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (restart),
    .load_val (load_val),
    .tick     (tick),
    .busy     (busy),
    .zero     (zero)
  );

  assign fire = busy && zero && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_hi <= 1'b0;
      drv_lo <= 1'b0;
    end else if (restart) begin
      drv_hi <= 1'b0;
      drv_lo <= 1'b0;
    end else if (fire) begin
      drv_hi <= (level == SIDE_HI);
      drv_lo <= (level == SIDE_LO);
    end
  end
endmodule

// File: rtl/pwm_dt_checker.sv
module pwm_dt_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic wave_in,
  input logic drv_hi,
  input logic drv_lo
);
  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n) !(drv_hi && drv_lo)); // R1
  AST_HI_OFF_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n) !wave_in |=> !drv_hi); // R3
  AST_LO_OFF_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n) wave_in |=> !drv_lo); // R3
  AST_DISABLE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n) !enable |=> (!drv_hi && !drv_lo)); // R8
  AST_HI_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(drv_hi) |-> ($past(enable) && $past(wave_in))); // R4
  AST_LO_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(drv_lo) |-> ($past(enable) && !$past(wave_in))); // R5
  AST_HI_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(drv_hi) |-> !$past(drv_lo)); // R9
  AST_LO_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(drv_lo) |-> !$past(drv_hi)); // R9
endmodule

bind pwm_deadtime_gen pwm_dt_checker chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .enable  (enable),
  .wave_in (wave_in),
  .drv_hi  (drv_hi),
  .drv_lo  (drv_lo)
);

// File: tb/pwm_deadtime_gen_tb_top.sv
module pwm_deadtime_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] dt_cfg = 8'h00;
  logic [1:0] ps_sel = 2'b00;
  logic       wave_in = 1'b0;
  logic       drv_hi, drv_lo;

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_tag = "R2";
  bit    done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  pwm_deadtime_gen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dt_cfg(dt_cfg),
    .ps_sel(ps_sel), .wave_in(wave_in), .drv_hi(drv_hi), .drv_lo(drv_lo)
  );

  // Behavioural reference: remaining clocks until the pending side turns on.
  bit m_level, m_pend, m_hi, m_lo;
  int m_wait;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_level = 0; m_pend = 1; m_wait = 0; m_hi = 0; m_lo = 0;
    end else if (!enable || (wave_in != m_level)) begin
      m_level = wave_in;
      m_pend  = 1;
      m_wait  = (wave_in ? int'(dt_cfg[7:4]) : int'(dt_cfg[3:0])) * (1 << ps_sel);
      m_hi = 0; m_lo = 0;
    end else if (m_pend) begin
      if (m_wait == 0) begin
        m_pend = 0; m_hi = m_level; m_lo = !m_level;
      end else m_wait--;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check("R1", int'(drv_hi && drv_lo), 0);
      check(cur_tag, int'({drv_hi, drv_lo}), int'({m_hi, m_lo}));
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Counts samples with the chosen output low, starting at the next negedge.
  task automatic measure(bit want_hi, output int cnt);
    cnt = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (want_hi ? drv_hi : drv_lo) break;
      cnt++;
    end
  endtask

  task automatic settle_low();
    int c;
    wave_in = 1'b0;
    measure(1'b0, c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int g;
    step(3);
    check("R2", int'({drv_hi, drv_lo}), 0);
    rst_n = 1'b1;
    step(3);
    check("R2", int'({drv_hi, drv_lo}), 0);

    // Full sweep: every nibble at every prescaler, nibbles set independently.
    for (int p = 0; p < 4; p++) begin
      enable = 1'b0;
      ps_sel = 2'(p);
      step(2);
      enable = 1'b1;
      settle_low();
      for (int n = 0; n < 16; n++) begin
        dt_cfg = {4'(n), 4'(15 - n)};
        cur_tag = "R4";
        wave_in = 1'b1;
        measure(1'b1, g);
        check(n == 0 ? "R9" : (p == 0 ? "R4" : "R6"), g, n * (1 << p) + 1);
        cur_tag = "R5";
        wave_in = 1'b0;
        measure(1'b0, g);
        check(n == 15 ? "R9" : (p == 0 ? "R5" : "R6"), g, (15 - n) * (1 << p) + 1);
      end
    end

    // Turn-off is prompt: the true side drops right after a low sample.
    cur_tag = "R3";
    ps_sel = 2'b00; dt_cfg = 8'h22;
    wave_in = 1'b1;
    measure(1'b1, g);
    wave_in = 1'b0;
    step(1);
    check("R3", int'(drv_hi), 0);
    measure(1'b0, g);
    check("R3", int'(drv_lo), 1);

    // Retrigger: rise then fall before the long true dead time ends.
    cur_tag = "R7";
    enable = 1'b0; ps_sel = 2'b01; dt_cfg = 8'hFF;
    step(2);
    enable = 1'b1;
    settle_low();
    wave_in = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 5; i++) begin
        step(1);
        if (drv_hi) seen++;
      end
      wave_in = 1'b0;
      measure(1'b0, g);
      check("R7", seen, 0);
      check("R7", g, 15 * 2 + 1);
    end

    // Disable blanks at once; re-enable restarts from the last disabled clock.
    cur_tag = "R8";
    ps_sel = 2'b00; dt_cfg = 8'h30;
    wave_in = 1'b1;
    measure(1'b1, g);
    enable = 1'b0;
    step(1);
    check("R8", int'({drv_hi, drv_lo}), 0);
    wave_in = 1'b0; step(2); wave_in = 1'b1; step(2);
    check("R8", int'({drv_hi, drv_lo}), 0);
    enable = 1'b1;
    measure(1'b1, g);
    check("R8", g, 3);
    enable = 1'b0; ps_sel = 2'b10;
    step(3);
    enable = 1'b1;
    measure(1'b1, g);
    check("R8", g, 12);

    step(4);
    finish_run();
  end
endmodule